// File: doc/BRIEF.md
# Majority-Vote Register Read Filter

This block stabilises reads from a register whose value can be corrupted at random moments. A read request from the host starts a burst of back-to-back samples of the register, one per clock. Every sample is sorted into a small table of distinct values, each with its own occurrence count. At the end, the value seen most often is returned together with a one-cycle completion pulse.

The burst is bounded by a planned sample total (100 by default). It ends early as soon as a single value has been seen in more than half of the planned samples, because no other value can then overtake it. When two values share the highest count, the one that reached that count first is returned. Each request starts from an empty table, so nothing carries over from earlier reads.

Top module: `majority_read_filter`

## Requirements
- R1: After reset, `busy` and `done` are low and `result` is zero.
- R2: A high `rd_req` seen at a clock edge while `busy` is low starts a read: `busy` is high from the next cycle, and `smp_data` is captured once per clock while `busy` is high.
- R3: A read takes at most SAMPLES samples; if no value reaches a majority, exactly SAMPLES samples are taken.
- R4: A read stops after the sample that gives one value a count above SAMPLES/2 (the 51st occurrence by default), so the number of samples equals the position of that sample.
- R5: `result` is the value with the highest occurrence count among the samples taken.
- R6: When several values share the highest count, `result` is the value that reached that count first.
- R7: `done` is high for exactly one cycle per read, in the cycle in which `busy` has just gone low, with `result` valid in that cycle.
- R8: `rd_req` is ignored while `busy` is high: it neither restarts the count nor causes an extra read.
- R9: The table and all counts are emptied at the start of each read, so samples from an earlier read have no influence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Read request, accepted when idle |
| smp_data | input | WIDTH | Current value of the register being sampled |
| busy | output | 1 | High while samples are being taken |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | WIDTH | Voted register value, held until the next read completes |

## Verification
The hardest case to reach is a tie that is resolved by arrival order, because it needs two values with the same final count and a full-length read without an early stop. The bench feeds an exact alternation of two values for all 100 samples, and also a sequence in which a later value overtakes an earlier leader. To show that the table is emptied, a read that would reach a majority at once if old counts survived follows a read built on the same value. A request is raised in the middle of a busy read to confirm that the count does not restart.

// File: rtl/majority_read_filter.sv
module majority_read_filter #(
  parameter int WIDTH   = 32,
  parameter int SAMPLES = 100,
  parameter int ENTRIES = SAMPLES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [WIDTH-1:0] smp_data,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  localparam int CW   = $clog2(SAMPLES + 1);
  localparam int FW   = $clog2(ENTRIES + 1);
  localparam int HALF = SAMPLES / 2;

  logic [WIDTH-1:0]   val [ENTRIES];
  logic [CW-1:0]      cnt [ENTRIES];
  logic [ENTRIES-1:0] hit;
  logic [FW-1:0]      fill, lead, hit_idx, slot;
  logic [CW-1:0]      n, maxc, newc, maxn;
  logic               hit_any, alloc, take, finish;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit[g] = (FW'(g) < fill) && (val[g] == smp_data);
  end

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit[i]) begin
        hit_any = 1'b1;
        hit_idx = FW'(i);
      end
  end

  assign slot   = hit_any ? hit_idx : fill;
  assign alloc  = !hit_any && (fill < FW'(ENTRIES));
  assign newc   = hit_any ? cnt[hit_idx] + 1'b1 : CW'(1);
  assign take   = (hit_any || alloc) && (newc > maxc);
  assign maxn   = take ? newc : maxc;
  assign finish = (maxn > CW'(HALF)) || (n == CW'(SAMPLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      n      <= '0;
      maxc   <= '0;
      lead   <= '0;
      fill   <= '0;
      for (int i = 0; i < ENTRIES; i++) cnt[i] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (rd_req) begin
          busy <= 1'b1;
          n    <= '0;
          maxc <= '0;
          lead <= '0;
          fill <= '0;
          for (int i = 0; i < ENTRIES; i++) cnt[i] <= '0;
        end
      end else begin
        if (hit_any) cnt[hit_idx] <= newc;
        else if (alloc) begin
          val[slot] <= smp_data;
          cnt[slot] <= newc;
          fill      <= fill + 1'b1;
        end
        if (take) lead <= slot;
        maxc <= maxn;
        n    <= n + 1'b1;
        if (finish) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= take ? smp_data : val[lead];
        end
      end
    end
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && rd_req |=> busy && n == '0);
  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> n < CW'(SAMPLES));
  p_no_majority_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> maxc <= CW'(HALF));
  p_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> maxc <= n);
  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_req |=> (n != '0) || done);
endmodule

// File: tb/test_majority_read_filter.sv
module test_majority_read_filter;
  localparam int W = 32;
  localparam int NS = 100;

  logic clk = 0, rst_n = 0, rd_req = 0;
  logic [W-1:0] smp_data = '0;
  logic busy, done;
  logic [W-1:0] result;

  majority_read_filter #(.WIDTH(W), .SAMPLES(NS)) i_majority_read_filter (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .smp_data(smp_data),
    .busy(busy), .done(done), .result(result));

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  logic [W-1:0] seq [NS];
  int idx = 0, bcnt = 0;
  logic [W-1:0] q_val [$];
  int q_n [$];
  string q_tag [$];

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // feeder: one new sample value per cycle while busy
  always @(negedge clk) if (busy) begin
    smp_data = seq[idx];
    idx++;
  end

  // monitor: counts busy cycles and compares results at done
  always @(negedge clk) begin
    if (busy) bcnt++;
    if (done) begin
      if (q_val.size() == 0) check(0, "R8 unexpected done", result, '0);
      else begin
        automatic logic [W-1:0] ev = q_val.pop_front();
        automatic int en = q_n.pop_front();
        automatic string t = q_tag.pop_front();
        check(result == ev, {t, " value"}, result, ev);
        check(bcnt == en, {t, " sample count"}, W'(bcnt), W'(en));
      end
      bcnt = 0;
    end
  end

  task automatic model(output logic [W-1:0] v, output int n);
    logic [W-1:0] vals [NS];
    int cnts [NS];
    int used = 0, maxc = 0, lead = 0;
    n = NS;
    for (int i = 0; i < NS; i++) begin
      int j = used;
      for (int k = used - 1; k >= 0; k--) if (vals[k] == seq[i]) j = k;
      if (j == used) begin vals[j] = seq[i]; cnts[j] = 1; used++; end
      else cnts[j]++;
      if (cnts[j] > maxc) begin maxc = cnts[j]; lead = j; end
      if (maxc > NS / 2) begin n = i + 1; break; end
    end
    v = vals[lead];
  endtask

  task automatic run(input string tag, input bit poke_busy);
    logic [W-1:0] ev;
    int en;
    model(ev, en);
    q_val.push_back(ev); q_n.push_back(en); q_tag.push_back(tag);
    idx = 0;
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
    check(busy == 1, "R2 busy after request", W'(busy), 1);
    if (poke_busy) begin
      repeat (5) @(negedge clk);
      rd_req = 1;
      @(negedge clk); rd_req = 0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check(busy == 0 && done == 0, "R7 R8 idle after done", {busy, done}, 0);
    check(q_val.size() == 0, "R8 all results seen", W'(q_val.size()), 0);
  endtask

  initial begin
    #1_500_000;
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && result == '0, "R1 reset state", {busy, done, result[1:0]}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NS; i++) seq[i] = 32'hA5A5_0001;
    run("R4 constant input early stop", 0);
    check(result == 32'hA5A5_0001, "R4 constant value", result, 32'hA5A5_0001);

    for (int i = 0; i < NS; i++) seq[i] = (i % 2 == 0) ? 32'h1111 : 32'h2222;
    run("R6 R3 two-way tie", 0);
    check(result == 32'h1111, "R6 first to reach count", result, 32'h1111);

    for (int i = 0; i < NS; i++) seq[i] = 32'h1000 + i * 7;
    run("R3 R5 all distinct", 0);

    for (int i = 0; i < NS; i++) seq[i] = (i < 3) ? 32'hAAAA : (i < 7) ? 32'hBBBB : 32'h5000 + i;
    run("R5 later value overtakes", 0);
    check(result == 32'hBBBB, "R5 overtaking value", result, 32'hBBBB);

    for (int i = 0; i < NS; i++) seq[i] = (i < 10 || i >= 70) ? 32'hAAAA : 32'hBBBB;
    run("R4 majority after lead change", 1);

    for (int i = 0; i < NS; i++) seq[i] = (i < 50) ? 32'hAAAA : 32'h7000 + i;
    run("R9 first read", 0);
    for (int i = 0; i < NS; i++) seq[i] = (i < 2) ? 32'hCCCC : (i == 2) ? 32'hAAAA : 32'h9000 + i;
    run("R9 fresh table", 0);
    check(result == 32'hCCCC, "R9 no carried counts", result, 32'hCCCC);

    for (int i = 0; i < NS; i++) seq[i] = (i % 3 == 0) ? 32'h3333 : 32'h4444;
    run("R5 R4 noisy majority", 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule